// File: doc/BRIEF.md
# Paged CSR Access Window

This block sits in front of a register file on a 32-bit memory-mapped CSR bus. The bus has a 12-bit physical byte address. The logical register space behind it is 16 bits wide. To reach logical offsets that the narrow physical space cannot decode directly, the upper quarter of the physical space acts as a window. A page number held in a shared control register selects which 1 KB slice of logical space the window shows. Every other physical address maps straight to the same logical offset.

Software changes pages with a read-modify-write of the control register. This leaves the two programmed-I/O direction enables and every other control bit unchanged. The control register sits at logical offset 0x808. It can be reached directly, and it can also be reached through the window with page 2. Logical offsets are backed by a block-RAM register file up to a parameterised limit. Offsets above that limit read as zero and ignore writes.

Top module: `csr_paged_window`

## Requirements
- R1: After reset the control register reads 0. This gives page 0 and both enable outputs low. `bus_rvalid` is low and `bus_rdata` is 0.
- R2: The control register is a full 32-bit read/write register at logical offset 0x808. Its page field is bits 18:13. The `pio_en` outputs show bits 1:0. Only a write that decodes to the control register changes it.
- R3: A physical address with bits 11:10 both set is a paged access. Its logical offset is {page, addr[9:0]}.
- R4: Any other physical address maps to the same logical offset, unpaged. Address bits 1:0 are ignored, so accesses are whole 32-bit words.
- R5: A write to the control register sets the page used by the very next bus access, with no added latency.
- R6: A read-modify-write that replaces only bits 18:13 leaves the enable bits and all other control bits unchanged.
- R7: Logical offsets at or above MEM_WORDS*4 (0x2000 by default) are unmapped. Reads of them return 0. Writes to them change no mapped register.
- R8: Read data appears on `bus_rdata` with `bus_rvalid` high exactly one cycle after a read request. In every other cycle `bus_rvalid` is low and `bus_rdata` is 0.
- R9: A paged access that resolves to logical 0x808 (page 2, physical 0xC08) reaches the same control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one word per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Physical byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pio_en | output | 2 | Control bits 1:0, the two programmed-I/O direction enables |

## Verification
The assertions assume that the bus issues at most one access per cycle and that `bus_we` is meaningful only while `bus_req` is high. The stimulus drives every request for exactly one cycle from the falling edge, so these assumptions hold. The assertions also rely on reads and writes never overlapping in the same cycle. The bench issues requests back to back, never concurrently, so this always holds. The memory has no reset, so the bench reads only words it has first written. The one exception is unmapped offsets, which must read as zero regardless.

// File: rtl/csr_pw_pkg.sv
package csr_pw_pkg;
  localparam int LOG_AW   = 16;          // logical byte address width
  localparam int PHYS_AW  = 12;          // physical byte address width
  localparam int OFF_W    = 10;          // in-page offset width
  localparam int PAGE_W   = LOG_AW - OFF_W;
  localparam int DATA_W   = 32;
  localparam int PAGE_LSB = 13;          // page field position in control
  localparam int EN_W     = 2;           // direction enables at bits 1:0
  localparam logic [LOG_AW-1:0] CTRL_OFF = 16'h0808;
endpackage

// File: rtl/csr_pw_xlate.sv
module csr_pw_xlate
  import csr_pw_pkg::*;
#(
  parameter int MEM_WORDS = 2048
) (
  input  logic [PHYS_AW-1:0] phys_addr,
  input  logic [PAGE_W-1:0]  page,
  output logic [LOG_AW-1:0]  eff,
  output logic               hit_ctrl,
  output logic               hit_mem
);
  localparam logic [31:0] MEM_LIM = 32'(MEM_WORDS * 4);

  logic              paged;
  logic [LOG_AW-1:0] raw;

  always_comb begin
    paged = &phys_addr[OFF_W+1:OFF_W];
    if (paged)
      raw = {page, phys_addr[OFF_W-1:0]};
    else
      raw = LOG_AW'(phys_addr);
    eff      = raw & ~LOG_AW'(3);
    hit_ctrl = (eff == CTRL_OFF);
    hit_mem  = !hit_ctrl && ({{(32-LOG_AW){1'b0}}, eff} < MEM_LIM);
  end
endmodule

// File: rtl/csr_pw_ctrl.sv
module csr_pw_ctrl
  import csr_pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [PAGE_W-1:0] page,
  output logic [EN_W-1:0]   en
);
  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_en)
      ctrl_q <= wdata;
  end

  assign page = ctrl_q[PAGE_LSB +: PAGE_W];
  assign en   = ctrl_q[EN_W-1:0];
endmodule

// File: rtl/csr_pw_regfile.sv
module csr_pw_regfile #(
  parameter int WORDS  = 2048,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we)
      mem[idx] <= wdata;
    if (re)
      rdata <= mem[idx];
  end
endmodule

// File: rtl/csr_paged_window.sv
module csr_paged_window
  import csr_pw_pkg::*;
#(
  parameter int MEM_WORDS = 2048,
  localparam int IDX_W = $clog2(MEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [PHYS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic [EN_W-1:0]    pio_en
);
  logic [LOG_AW-1:0] eff;
  logic              hit_ctrl, hit_mem;
  logic [PAGE_W-1:0] page;
  logic [DATA_W-1:0] ctrl_q, mem_rd;
  logic              rd_req;

  logic              rvalid_q, sel_ctrl_q, sel_mem_q;
  logic [DATA_W-1:0] snap_q;

  assign rd_req = bus_req && !bus_we;

  csr_pw_xlate #(.MEM_WORDS(MEM_WORDS)) u_xlate (
    .phys_addr (bus_addr),
    .page      (page),
    .eff       (eff),
    .hit_ctrl  (hit_ctrl),
    .hit_mem   (hit_mem)
  );

  csr_pw_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_req && bus_we && hit_ctrl),
    .wdata  (bus_wdata),
    .ctrl_q (ctrl_q),
    .page   (page),
    .en     (pio_en)
  );

  csr_pw_regfile #(.WORDS(MEM_WORDS), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .we    (bus_req && bus_we && hit_mem),
    .re    (rd_req && hit_mem),
    .idx   (eff[IDX_W+1:2]),
    .wdata (bus_wdata),
    .rdata (mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q   <= 1'b0;
      sel_ctrl_q <= 1'b0;
      sel_mem_q  <= 1'b0;
      snap_q     <= '0;
    end else begin
      rvalid_q   <= rd_req;
      sel_ctrl_q <= rd_req && hit_ctrl;
      sel_mem_q  <= rd_req && hit_mem;
      if (rd_req && hit_ctrl)
        snap_q <= ctrl_q;
    end
  end

  always_comb begin
    bus_rvalid = rvalid_q;
    if (sel_ctrl_q)
      bus_rdata = snap_q;
    else if (sel_mem_q)
      bus_rdata = mem_rd;
    else
      bus_rdata = '0;
  end
endmodule

// File: rtl/csr_pw_chk.sv
module csr_pw_chk
  import csr_pw_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               bus_req,
  input logic               bus_we,
  input logic [PHYS_AW-3:0] bus_waddr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               bus_rvalid,
  input logic [EN_W-1:0]    pio_en,
  input logic [PAGE_W-1:0]  page,
  input logic [LOG_AW-1:0]  eff,
  input logic               hit_ctrl,
  input logic               hit_mem
);
  // R8: read answered in the following cycle
  p_rvalid_rd_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  // R8: no valid without a read the cycle before
  p_rvalid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  // R8: data bus quiet when not valid
  p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> (bus_rdata == '0));

  // R2: control changes only on a decoded control write
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we && hit_ctrl) |=> ($stable(pio_en) && $stable(page)));

  // R3: window accesses combine page and in-page offset
  p_paged_map_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && (&bus_waddr[OFF_W-1:OFF_W-2])) |->
      (eff[LOG_AW-1:OFF_W] == page && eff[OFF_W-1:2] == bus_waddr[OFF_W-3:0]));

  // R4: other accesses map straight through, word aligned
  p_direct_map_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !(&bus_waddr[OFF_W-1:OFF_W-2])) |->
      (eff[PHYS_AW-1:2] == bus_waddr && eff[LOG_AW-1:PHYS_AW] == '0 && eff[1:0] == 2'b00));

  // R7: unmapped reads return zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && !hit_ctrl && !hit_mem) |=> (bus_rdata == '0));
endmodule

bind csr_paged_window csr_pw_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_waddr  (bus_addr[11:2]),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pio_en     (pio_en),
  .page       (page),
  .eff        (eff),
  .hit_ctrl   (hit_ctrl),
  .hit_mem    (hit_mem)
);

// File: tb/sim_csr_paged_window.sv
module sim_csr_paged_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  pio_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  csr_paged_window u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pio_en(pio_en)
  );

  localparam logic [11:0] CTRL = 12'h808;

  function automatic logic [31:0] with_page(input logic [31:0] v, input int pg);
    return (v & ~(32'h3f << 13)) | ((32'(pg) & 32'h3f) << 13);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // each access occupies one cycle, driven and finished on falling edges
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, d, v);
    check({tag, " valid"}, 32'(v), 32'd1);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rvalid idle", 32'(bus_rvalid), 32'd0);
    check("R1 rdata idle", bus_rdata, 32'd0);
    check("R1 pio_en", 32'(pio_en), 32'd0);
    rd_check("R1 ctrl reset", CTRL, 32'd0);
    @(negedge clk);
    check("R8 rvalid drops", 32'(bus_rvalid), 32'd0);
    check("R8 rdata zero when idle", bus_rdata, 32'd0);
  endtask

  task automatic t_ctrl;
    wr(CTRL, 32'hA5A5_0003);
    check("R2 pio_en after write", 32'(pio_en), 32'd3);
    rd_check("R2 ctrl readback", CTRL, 32'hA5A5_0003);
    wr(12'h804, 32'h0000_0000);
    check("R2 neighbour write ignored", 32'(pio_en), 32'd3);
    wr(CTRL, 32'h0000_0000);
    check("R2 pio_en cleared", 32'(pio_en), 32'd0);
  endtask

  task automatic t_unpaged;
    wr(12'h000, 32'h0000_1000);
    wr(12'h004, 32'h1111_1111);
    wr(12'h7FC, 32'h7777_7FFC);
    wr(12'hBFC, 32'hBBBB_BFFC);
    rd_check("R4 direct 0x004", 12'h004, 32'h1111_1111);
    rd_check("R4 direct 0x7FC", 12'h7FC, 32'h7777_7FFC);
    rd_check("R4 direct 0xBFC", 12'hBFC, 32'hBBBB_BFFC);
    rd_check("R4 byte bits ignored", 12'h006, 32'h1111_1111);
  endtask

  task automatic t_paged;
    wr(CTRL, with_page(32'h1, 1));
    wr(12'hC10, 32'hCAFE_0001);
    rd_check("R3 page1 alias of 0x410", 12'h410, 32'hCAFE_0001);
    wr(CTRL, with_page(32'h1, 3));
    wr(12'hC00, 32'h3333_0000);
    rd_check("R3 page3 readback", 12'hC00, 32'h3333_0000);
    wr(CTRL, with_page(32'h1, 0));
    rd_check("R3 page0 shows logical 0x000", 12'hC00, 32'h0000_1000);
    check("R6 enable kept over pages", 32'(pio_en), 32'd1);
  endtask

  task automatic t_switch;
    logic [31:0] d; logic v;
    wr(CTRL, with_page(32'h0, 5));
    wr(12'hC20, 32'h5555_1420);
    wr(CTRL, with_page(32'h0, 4));
    wr(12'hC20, 32'h4444_1020);         // next cycle uses page 4
    wr(CTRL, with_page(32'h0, 5));
    rd(12'hC20, d, v);                  // next cycle uses page 5
    check("R5 read after switch to 5", d, 32'h5555_1420);
    wr(CTRL, with_page(32'h0, 4));
    rd(12'hC20, d, v);
    check("R5 write after switch to 4", d, 32'h4444_1020);
  endtask

  task automatic t_rmw;
    logic [31:0] d, want; logic v;
    wr(CTRL, 32'h0F00_0002 | (32'd9 << 13));
    rd(CTRL, d, v);
    want = with_page(d, 7);
    wr(CTRL, want);
    check("R6 pio_en preserved", 32'(pio_en), 32'd2);
    rd_check("R6 other bits preserved", CTRL, 32'h0F00_0002 | (32'd7 << 13));
  endtask

  task automatic t_ctrl_via_page;
    wr(CTRL, with_page(32'h0, 2));
    rd_check("R9 paged view of control", 12'hC08, with_page(32'h0, 2));
    wr(12'hC08, with_page(32'h1, 2));
    check("R9 paged control write", 32'(pio_en), 32'd1);
    rd_check("R9 direct view agrees", CTRL, with_page(32'h1, 2));
  endtask

  task automatic t_unmapped;
    wr(12'h020, 32'h5555_AAAA);
    wr(CTRL, with_page(32'h0, 8));      // logical 0x2000..0x23FF
    wr(12'hC20, 32'hDEAD_BEEF);
    rd_check("R7 unmapped read zero", 12'hC20, 32'd0);
    wr(CTRL, with_page(32'h0, 63));
    rd_check("R7 top page reads zero", 12'hFFC, 32'd0);
    rd_check("R7 mapped word untouched", 12'h020, 32'h5555_AAAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_ctrl;
    t_unpaged;
    t_paged;
    t_switch;
    t_rmw;
    t_ctrl_via_page;
    t_unmapped;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule